// File: doc/BRIEF.md
# SDA Output Hold Delay and Input Glitch Filter

This block sits between the bit-shifting logic of an I2C master and the SDA pad. Every change that the master makes to its SDA drive value after SCL falls is held back by a programmable number of system clocks. This gives the receiving device data hold time after the clock edge. The delay is set in coarse steps of five clocks. If SCL rises again before the delay has run out, the pending drive value is applied at once, so the hold delay can never use up setup time.

On the input side, an optional glitch filter cleans the raw SDA level before the master samples it. When the filter is enabled, a new level is accepted only after it has been seen on three consecutive system clocks. When the filter is disabled, the raw level passes through a single register.

A 3-bit line-control word configures both features. The block captures this word only on an SCL falling edge. A write made while a delay is counting therefore cannot shorten or stretch that delay.

Top module: `sda_line_conditioner`

## Requirements
- R1: After reset, `sda_oe` is 0 (pad released), `sda_filt` is 1, and the captured configuration is zero.
- R2: `line_cfg[1:0]` is the step count and `line_cfg[2]` enables the input filter. One step is 5 system clocks, so the hold is 0, 5, 10 or 15 clocks.
- R3: When SCL falls with a step count of s, the drive value present at that edge appears on `sda_oe` 5*s+1 rising clock edges after it, counting the falling-edge detection edge as the first.
- R4: Outside a hold window, `sda_oe` follows `sda_drive_low` with exactly one clock of latency, whether SCL is high or low.
- R5: An SCL rising edge during a hold window ends the window: `sda_oe` takes the current drive value on that same clock edge.
- R6: With the filter captured as enabled, `sda_filt` changes only after `sda_raw` has held a new level for 3 consecutive clocks, and it shows that level 4 clock edges after the raw change. A pulse of 2 clocks or fewer does not appear.
- R7: With the filter captured as disabled, `sda_filt` equals `sda_raw` delayed by one clock, and single-clock pulses pass through.
- R8: `line_cfg` is captured only on an SCL falling edge. A change during a hold window does not alter that window, and a change to the filter bit while SCL is high has no effect until the next falling edge.
- R9: A configuration value of zero gives no hold delay and no filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_cfg | input | 3 | Line-control word: [1:0] hold steps, [2] filter enable |
| sda_drive_low | input | 1 | Master's SDA drive request, 1 = pull low |
| scl_in | input | 1 | SCL level, synchronous to clk |
| sda_raw | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | Delayed SDA pull-low enable to the pad |
| sda_filt | output | 1 | Conditioned SDA level to the master |

## Verification
The hold path is driven through all eight configuration words, each with a drive change placed on an SCL fall. This separates a wrong step size, a swapped field and a filter bit that leaks into the delay. Further falls check three cases: an early SCL rise that cuts the window short, a configuration write during the count, and a zero word. The filter path is tried with low pulses of one, two and three clocks, both enabled and disabled. This distinguishes a short-window filter, a pass-through and a filter enable taken straight from the write rather than from the captured word.

// File: rtl/sda_line_pkg.sv
package sda_line_pkg;

    // Width of the step-count field of the line-control word.
    localparam int STEP_W       = 2;
    // Default number of system clocks per hold step.
    localparam int STEP_CLKS_D  = 5;
    // Default number of agreeing samples for the input filter.
    localparam int FILT_LEN_D   = 3;

    // Line-control word: filter enable on top, step count below.
    typedef struct packed {
        logic              filt_en;
        logic [STEP_W-1:0] steps;
    } line_cfg_t;

    localparam int CFG_W = $bits(line_cfg_t);

    // Longest hold, in clocks, for a given step size.
    function automatic int max_hold(input int step_clks);
        return step_clks * ((1 << STEP_W) - 1);
    endfunction

    // Counter width able to hold the longest hold value.
    function automatic int hold_cnt_w(input int step_clks);
        int mh;
        mh = max_hold(step_clks);
        return (mh < 1) ? 1 : $clog2(mh + 1);
    endfunction

endpackage

// File: rtl/sda_scl_edge.sv
module sda_scl_edge (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    output logic scl_fall,
    output logic scl_rise
);
    logic scl_q;

    // The bus idles high, so the previous level starts at 1.
    always_ff @(posedge clk) begin
        if (rst) scl_q <= 1'b1;
        else     scl_q <= scl_in;
    end

    assign scl_fall = scl_q & ~scl_in;
    assign scl_rise = ~scl_q & scl_in;
endmodule

// File: rtl/sda_hold_delay.sv
module sda_hold_delay
    import sda_line_pkg::*;
#(
    parameter int STEP_CLKS = STEP_CLKS_D
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_fall,
    input  logic              scl_rise,
    input  logic [STEP_W-1:0] steps,
    input  logic              drive_low,
    output logic              oe,
    output logic              busy
);
    localparam int CNT_W = hold_cnt_w(STEP_CLKS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;
    logic             oe_q;

    assign load_val = CNT_W'(int'(steps) * STEP_CLKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            oe_q  <= 1'b0;
        end else if (scl_fall) begin
            // Start a new hold window; with zero steps apply now.
            cnt_q <= load_val;
            if (load_val == '0) oe_q <= drive_low;
        end else if (scl_rise) begin
            // Setup time wins: flush any pending value.
            cnt_q <= '0;
            oe_q  <= drive_low;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) oe_q <= drive_low;
        end else begin
            oe_q <= drive_low;
        end
    end

    assign oe   = oe_q;
    assign busy = (cnt_q != '0);
endmodule

// File: rtl/sda_glitch_filter.sv
module sda_glitch_filter
    import sda_line_pkg::*;
#(
    parameter int FILT_LEN = FILT_LEN_D
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic raw,
    output logic filt,
    output logic agree
);
    logic filt_q;

    generate
        if (FILT_LEN <= 1) begin : g_bypass
            // A single sample always agrees with itself.
            always_ff @(posedge clk) begin
                if (rst) filt_q <= 1'b1;
                else     filt_q <= raw;
            end
            assign agree = 1'b1;
        end else begin : g_window
            logic [FILT_LEN-1:0] hist_q;
            logic                all_hi;
            logic                all_lo;

            always_ff @(posedge clk) begin
                if (rst) hist_q <= '1;
                else     hist_q <= {hist_q[FILT_LEN-2:0], raw};
            end

            always_comb begin
                all_hi = 1'b1;
                all_lo = 1'b1;
                for (int i = 0; i < FILT_LEN; i++) begin
                    all_hi = all_hi & hist_q[i];
                    all_lo = all_lo & ~hist_q[i];
                end
            end

            assign agree = all_hi | all_lo;

            always_ff @(posedge clk) begin
                if (rst)        filt_q <= 1'b1;
                else if (!en)   filt_q <= raw;
                else if (agree) filt_q <= hist_q[0];
            end
        end
    endgenerate

    assign filt = filt_q;
endmodule

// File: rtl/sda_line_conditioner.sv
module sda_line_conditioner
    import sda_line_pkg::*;
#(
    parameter int STEP_CLKS = STEP_CLKS_D,
    parameter int FILT_LEN  = FILT_LEN_D
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] line_cfg,
    input  logic       sda_drive_low,
    input  logic       scl_in,
    input  logic       sda_raw,
    output logic       sda_oe,
    output logic       sda_filt
);
    line_cfg_t cfg_wr;
    line_cfg_t cfg_act;
    logic      scl_fall;
    logic      scl_rise;
    logic      hold_busy;
    logic      filt_agree;

    assign cfg_wr = line_cfg_t'(line_cfg);

    sda_scl_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_in),
        .scl_fall (scl_fall),
        .scl_rise (scl_rise)
    );

    // The configuration word is captured only on an SCL fall.
    always_ff @(posedge clk) begin
        if (rst)           cfg_act <= '0;
        else if (scl_fall) cfg_act <= cfg_wr;
    end

    // The hold window started at this fall uses the word just captured.
    sda_hold_delay #(.STEP_CLKS(STEP_CLKS)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .scl_fall  (scl_fall),
        .scl_rise  (scl_rise),
        .steps     (cfg_wr.steps),
        .drive_low (sda_drive_low),
        .oe        (sda_oe),
        .busy      (hold_busy)
    );

    sda_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst   (rst),
        .en    (cfg_act.filt_en),
        .raw   (sda_raw),
        .filt  (sda_filt),
        .agree (filt_agree)
    );
endmodule

// File: rtl/sda_line_conditioner_chk.sv
module sda_line_conditioner_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] line_cfg,
    input logic       sda_drive_low,
    input logic       sda_raw,
    input logic       sda_oe,
    input logic       sda_filt,
    input logic       scl_fall,
    input logic       scl_rise,
    input logic       hold_busy,
    input logic       filt_agree,
    input logic [2:0] act_cfg
);
    // R3: a fall with nonzero steps freezes the pad output on that edge.
    p_fall_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        (scl_fall && line_cfg[1:0] != 2'd0) |=> $stable(sda_oe));

    // R5: an SCL rise applies the drive value on the same edge.
    p_rise_flush_r5: assert property (@(posedge clk) disable iff (rst)
        scl_rise |=> (sda_oe == $past(sda_drive_low)));

    // R4: with no window running, the output tracks the drive one clock later.
    p_idle_track_r4: assert property (@(posedge clk) disable iff (rst)
        (!hold_busy && !scl_fall) |=> (sda_oe == $past(sda_drive_low)));

    // R8: the captured word moves only on an SCL fall.
    p_cfg_capture_r8: assert property (@(posedge clk) disable iff (rst)
        !scl_fall |=> $stable(act_cfg));

    // R6: with filtering on, no change without an agreeing window.
    p_filter_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (act_cfg[2] && !filt_agree) |=> $stable(sda_filt));

    // R7: with filtering off, the raw level passes after one clock.
    p_filter_pass_r7: assert property (@(posedge clk) disable iff (rst)
        !act_cfg[2] |=> (sda_filt == $past(sda_raw)));
endmodule

bind sda_line_conditioner sda_line_conditioner_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .line_cfg      (line_cfg),
    .sda_drive_low (sda_drive_low),
    .sda_raw       (sda_raw),
    .sda_oe        (sda_oe),
    .sda_filt      (sda_filt),
    .scl_fall      (scl_fall),
    .scl_rise      (scl_rise),
    .hold_busy     (hold_busy),
    .filt_agree    (filt_agree),
    .act_cfg       (cfg_act)
);

// File: tb/sda_line_conditioner_test.sv
module sda_line_conditioner_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] line_cfg = 3'd0;
    logic       sda_drive_low = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_raw = 1'b1;
    logic       sda_oe;
    logic       sda_filt;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    sda_line_conditioner uut (
        .clk           (clk),
        .rst           (rst),
        .line_cfg      (line_cfg),
        .sda_drive_low (sda_drive_low),
        .scl_in        (scl_in),
        .sda_raw       (sda_raw),
        .sda_oe        (sda_oe),
        .sda_filt      (sda_filt)
    );

    // Configuration word and expected edges until sda_oe rises (R2, R3).
    localparam int NVEC = 8;
    localparam logic [7:0] VEC [NVEC] = '{
        {3'd0, 5'd1},  {3'd1, 5'd6},  {3'd2, 5'd11}, {3'd3, 5'd16},
        {3'd4, 5'd1},  {3'd5, 5'd6},  {3'd6, 5'd11}, {3'd7, 5'd16}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Return SCL high with the drive released and the output settled.
    task automatic settle_high();
        scl_in = 1'b1;
        sda_drive_low = 1'b0;
        tick(3);
    endtask

    // Fall SCL with a drive change; count edges until sda_oe goes high.
    task automatic fall_measure(input logic [2:0] cfg, output int n);
        n = 0;
        line_cfg = cfg;
        scl_in = 1'b0;
        sda_drive_low = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (sda_oe && n == 0) n = k;
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        tick(3);
        // R1: reset state
        chk("R1 oe", int'(sda_oe), 0);
        chk("R1 filt", int'(sda_filt), 1);
        rst = 1'b0;
        tick(2);
        chk("R1 oe after release", int'(sda_oe), 0);

        // R2 R3: every configuration word, drive change on the fall
        for (int v = 0; v < NVEC; v++) begin
            fall_measure(VEC[v][7:5], n);
            chk($sformatf("R3 cfg=%0d hold", VEC[v][7:5]), n, int'(VEC[v][4:0]));
            settle_high();
        end

        // R9: zero word, no delay
        fall_measure(3'd0, n);
        chk("R9 zero word delay", n, 1);

        // R4: SCL low, window over, drive toggles follow after one clock
        sda_drive_low = 1'b0;
        tick(1);
        chk("R4 low-phase track", int'(sda_oe), 0);
        settle_high();
        sda_drive_low = 1'b1;
        tick(1);
        chk("R4 high-phase track", int'(sda_oe), 1);
        settle_high();

        // R5: rise after 4 edges of a 15-clock window flushes at once
        line_cfg = 3'd3;
        scl_in = 1'b0;
        sda_drive_low = 1'b1;
        tick(4);
        chk("R5 still held", int'(sda_oe), 0);
        scl_in = 1'b1;
        tick(1);
        chk("R5 flushed on rise", int'(sda_oe), 1);
        settle_high();

        // R8: word changed mid-window leaves the window unchanged
        line_cfg = 3'd3;
        scl_in = 1'b0;
        sda_drive_low = 1'b1;
        tick(2);
        line_cfg = 3'd0;
        n = 0;
        for (int k = 3; k <= 30; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (sda_oe && n == 0) n = k;
        end
        chk("R8 mid-window write ignored", n, 16);
        settle_high();
        fall_measure(3'd0, n);
        chk("R8 new word at next fall", n, 1);
        settle_high();

        // R7: filter captured off, 1-clock low pulse passes
        sda_raw = 1'b0;
        tick(1);
        chk("R7 pulse low", int'(sda_filt), 0);
        sda_raw = 1'b1;
        tick(1);
        chk("R7 pulse back high", int'(sda_filt), 1);

        // R8: enabling filter while SCL high has no effect yet
        line_cfg = 3'd4;
        tick(1);
        sda_raw = 1'b0;
        tick(1);
        chk("R8 filter not yet active", int'(sda_filt), 0);
        sda_raw = 1'b1;
        tick(2);

        // Capture filter-on with a fall, return high
        scl_in = 1'b0;
        tick(2);
        scl_in = 1'b1;
        line_cfg = 3'd0;
        tick(5);

        // R6: 1- and 2-clock pulses rejected
        sda_raw = 1'b0;
        tick(1);
        sda_raw = 1'b1;
        tick(1);
        chk("R6 1-clock pulse", int'(sda_filt), 1);
        tick(3);
        chk("R6 1-clock pulse later", int'(sda_filt), 1);
        sda_raw = 1'b0;
        tick(2);
        sda_raw = 1'b1;
        tick(1);
        chk("R6 2-clock pulse", int'(sda_filt), 1);
        tick(3);
        chk("R6 2-clock pulse later", int'(sda_filt), 1);
        tick(3);

        // R6: 3-clock low accepted on the fourth edge
        sda_raw = 1'b0;
        tick(3);
        chk("R6 before acceptance", int'(sda_filt), 1);
        tick(1);
        chk("R6 accepted low", int'(sda_filt), 0);
        tick(3);
        sda_raw = 1'b1;
        tick(4);
        chk("R6 accepted high", int'(sda_filt), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule